// File: doc/BRIEF.md
# Debug Control Register with Breakpoint Interrupt

This block holds the debug control word of a processor core. Two agents can write it: the processor itself and an external debug port. The stored fields drive a set of control outputs: the breakpoint mode, the trace-output disable, the processor write lock, the emulator address map, trace-to-emulator, forced emulator entry, the operand capture select and the user halt permission. Each port has its own read view. The external view carries a fixed hardware revision code. The processor view shows zero in that field.

The block also watches an asynchronous, active-low breakpoint pin. When breakpoint mode is on, a high-to-low transition on the pin arms a pending debug interrupt. The interrupt is taken at the next instruction sample point and is held until the core acknowledges it. A second interrupt cannot start while one is pending or being serviced. A combinational halt-permitted output combines the current privilege level with the user halt permission bit.

Top module: `dbg_ctrl_reg`

## Requirements
- R1: After reset, every control output, `dbg_irq_pend`, `dbg_irq_req` and `cpu_rdata` are zero. `ext_rdata` equals 32'h00B0_0000.
- R2: Bits [23:20] of `ext_rdata` always read 4'b1011. The same bits of `cpu_rdata` always read zero. Writes never change them.
- R3: Bit 19, bits [31:24] and bits [9:0] read zero from both ports, whatever was written.
- R4: An external write loads bits [18:10] of `ext_wdata` into the fields. The layout is: bit 18 breakpoint mode, 17 trace disable, 16 write lock, 15 address map, 14 trace-to-emulator, 13 force emulator, [12:11] capture select, 10 user halt. The new value shows on reads and control outputs one clock after the write.
- R5: While the write lock is 0, a processor write loads bits 18, 17 and [15:10]. A processor write never changes the write lock bit.
- R6: While the write lock is 1, a processor write changes nothing.
- R7: When both ports write in the same cycle, the register takes the external data and ignores the processor data.
- R8: With breakpoint mode 1, a high-to-low transition of `bkpt_n` sets `dbg_irq_pend`. The flag is seen after the third rising clock edge that follows the pin change (two synchronizer stages, then edge detection). It is not set after the second edge.
- R9: With breakpoint mode 0, a falling edge does not set the pending flag. A low-to-high transition never sets it.
- R10: A pending request waits, however many cycles pass, until `sample_pt` is high at a clock edge. After that edge `dbg_irq_req` is 1 and `dbg_irq_pend` is 0.
- R11: Breakpoint edges are ignored while a request is pending or being serviced. No second request is queued.
- R12: `irq_ack` clears both `dbg_irq_pend` and `dbg_irq_req` at the next clock edge. Later breakpoint edges are then accepted again.
- R13: `halt_ok` is 1 exactly when `cpu_super` is 1 or the user halt bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read view (revision hidden) |
| ext_wr_en | input | 1 | External debug port write strobe |
| ext_wdata | input | 32 | External write data |
| ext_rdata | output | 32 | External read view (revision shown) |
| bkpt_n | input | 1 | Asynchronous active-low breakpoint pin |
| sample_pt | input | 1 | Instruction sample-point strobe |
| irq_ack | input | 1 | Debug interrupt acknowledge |
| cpu_super | input | 1 | Processor is in supervisor mode |
| ctl_bkpt_mode | output | 1 | Breakpoint pin raises interrupts on falling edges |
| ctl_trace_off | output | 1 | Trace clock and data outputs held quiet |
| ctl_wr_inhibit | output | 1 | Processor writes locked |
| ctl_map | output | 1 | Emulator references use the special address space |
| ctl_trc_emu | output | 1 | Trace exception enters emulator mode |
| ctl_force_emu | output | 1 | Force emulator mode |
| ctl_capture | output | 2 | Operand capture select (none, writes, reads, both) |
| ctl_user_halt | output | 1 | Halt permitted in user mode |
| dbg_irq_pend | output | 1 | Breakpoint edge waiting for a sample point |
| dbg_irq_req | output | 1 | Debug interrupt taken and being serviced |
| halt_ok | output | 1 | Halt instruction permitted now |

## Verification
A write is due on the reads and control outputs one clock later. The bench drives each write after a falling clock edge and compares at the next falling edge against its own register model. `halt_ok` and the read views are combinational, so they are compared in that same sampling window. The pending flag is due on the third rising edge after the pin changes. The bench checks that it is still clear after two edges and set after three. The interrupt request is due one edge after a sample point, and the clear is due one edge after an acknowledge. Each of these is sampled on the falling edge right after the edge that should cause it.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

    localparam int unsigned FLD_HI   = 18;
    localparam int unsigned FLD_LO   = 10;
    localparam int unsigned RSV_POS  = 19;
    localparam int unsigned REV_LO   = 20;
    localparam int unsigned REV_HI   = 23;
    localparam int unsigned LOCK_POS = 16;

    // Member order matches register bits 18 down to 10
    typedef struct packed {
        logic       bkpt_mode;
        logic       trace_off;
        logic       wr_inhibit;
        logic       map_sel;
        logic       trc_emu;
        logic       force_emu;
        logic [1:0] capture;
        logic       user_halt;
    } dbg_fields_t;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_PEND  = 2'd1,
        BK_TAKEN = 2'd2
    } bk_state_e;

endpackage

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
    import dbg_ctrl_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter logic [3:0]  REV_CODE = 4'b1011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_en,
    input  logic [REG_W-1:0] cpu_wdata,
    input  logic             ext_wr_en,
    input  logic [REG_W-1:0] ext_wdata,
    output dbg_fields_t      fields_o,
    output logic [REG_W-1:0] cpu_rdata_o,
    output logic [REG_W-1:0] ext_rdata_o
);

    localparam int unsigned FLD_W = FLD_HI - FLD_LO + 1;

    typedef struct packed {
        dbg_fields_t fld;
    } csr_state_t;

    csr_state_t st_d, st_q;
    logic       cpu_allowed;
    logic [REG_W-1:0] view_base;

    always_comb begin
        st_d        = st_q;
        cpu_allowed = cpu_wr_en && !st_q.fld.wr_inhibit;
        if (ext_wr_en) begin
            st_d.fld = dbg_fields_t'(ext_wdata[FLD_HI:FLD_LO]);
        end else if (cpu_allowed) begin
            st_d.fld            = dbg_fields_t'(cpu_wdata[FLD_HI:FLD_LO]);
            st_d.fld.wr_inhibit = st_q.fld.wr_inhibit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        view_base                = '0;
        view_base[FLD_HI:FLD_LO] = st_q.fld[FLD_W-1:0];
        cpu_rdata_o              = view_base;
        ext_rdata_o              = view_base;
        ext_rdata_o[REV_HI:REV_LO] = REV_CODE;
    end

    assign fields_o = st_q.fld;

endmodule

// File: rtl/dbg_bkpt_edge.sv
module dbg_bkpt_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [SYNC_STAGES-1:0] chain_next;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            assign chain_next = pin_n_i;
        end else begin : g_multi
            assign chain_next = {st_q.chain[SYNC_STAGES-2:0], pin_n_i};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = chain_next;
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev && !st_q.chain[LAST];

endmodule

// File: rtl/dbg_irq_seq.sv
module dbg_irq_seq
    import dbg_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic mode_i,
    input  logic sample_i,
    input  logic ack_i,
    output logic pend_o,
    output logic req_o
);

    typedef struct packed {
        bk_state_e state;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            BK_IDLE: begin
                if (fall_i && mode_i) st_d.state = BK_PEND;
            end
            BK_PEND: begin
                if (ack_i)         st_d.state = BK_IDLE;
                else if (sample_i) st_d.state = BK_TAKEN;
            end
            BK_TAKEN: begin
                if (ack_i) st_d.state = BK_IDLE;
            end
            default: st_d.state = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= BK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = (st_q.state == BK_PEND);
    assign req_o  = (st_q.state == BK_TAKEN);

endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_ctrl_pkg::*;
#(
    parameter int unsigned REG_W       = 32,
    parameter logic [3:0]  REV_CODE    = 4'b1011,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_en,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             ext_wr_en,
    input  logic [REG_W-1:0] ext_wdata,
    output logic [REG_W-1:0] ext_rdata,
    input  logic             bkpt_n,
    input  logic             sample_pt,
    input  logic             irq_ack,
    input  logic             cpu_super,
    output logic             ctl_bkpt_mode,
    output logic             ctl_trace_off,
    output logic             ctl_wr_inhibit,
    output logic             ctl_map,
    output logic             ctl_trc_emu,
    output logic             ctl_force_emu,
    output logic [1:0]       ctl_capture,
    output logic             ctl_user_halt,
    output logic             dbg_irq_pend,
    output logic             dbg_irq_req,
    output logic             halt_ok
);

    dbg_fields_t fields;
    logic        bkpt_fall;

    dbg_csr_file #(
        .REG_W    (REG_W),
        .REV_CODE (REV_CODE)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wdata   (cpu_wdata),
        .ext_wr_en   (ext_wr_en),
        .ext_wdata   (ext_wdata),
        .fields_o    (fields),
        .cpu_rdata_o (cpu_rdata),
        .ext_rdata_o (ext_rdata)
    );

    dbg_bkpt_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (bkpt_n),
        .fall_o  (bkpt_fall)
    );

    dbg_irq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (bkpt_fall),
        .mode_i   (fields.bkpt_mode),
        .sample_i (sample_pt),
        .ack_i    (irq_ack),
        .pend_o   (dbg_irq_pend),
        .req_o    (dbg_irq_req)
    );

    assign ctl_bkpt_mode  = fields.bkpt_mode;
    assign ctl_trace_off  = fields.trace_off;
    assign ctl_wr_inhibit = fields.wr_inhibit;
    assign ctl_map        = fields.map_sel;
    assign ctl_trc_emu    = fields.trc_emu;
    assign ctl_force_emu  = fields.force_emu;
    assign ctl_capture    = fields.capture;
    assign ctl_user_halt  = fields.user_halt;
    assign halt_ok        = cpu_super || fields.user_halt;

endmodule

// File: rtl/dbg_ctrl_checker.sv
module dbg_ctrl_checker #(
    parameter int unsigned REG_W    = 32,
    parameter logic [3:0]  REV_CODE = 4'b1011
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr_en,
    input logic [REG_W-1:0] cpu_rdata,
    input logic             ext_wr_en,
    input logic [REG_W-1:0] ext_wdata,
    input logic [REG_W-1:0] ext_rdata,
    input logic             sample_pt,
    input logic             irq_ack,
    input logic             cpu_super,
    input logic             ctl_bkpt_mode,
    input logic             ctl_wr_inhibit,
    input logic             dbg_irq_pend,
    input logic             dbg_irq_req,
    input logic             halt_ok
);

    p_rev_views_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rdata[23:20] == REV_CODE && cpu_rdata[23:20] == 4'b0000);

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rdata[19] && !cpu_rdata[19]);

    p_lock_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_en |=> $stable(ctl_wr_inhibit));

    p_locked_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !ext_wr_en && ctl_wr_inhibit) |=> $stable(ext_rdata));

    p_ext_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_en |=> ext_rdata[18:10] == $past(ext_wdata[18:10]));

    p_mode_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_bkpt_mode && !dbg_irq_pend && !dbg_irq_req) |=> !dbg_irq_pend);

    p_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_irq_pend && sample_pt && !irq_ack) |=> (dbg_irq_req && !dbg_irq_pend));

    p_no_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_irq_req && dbg_irq_pend));

    p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!dbg_irq_req && !dbg_irq_pend));

    p_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halt_ok == (cpu_super || ext_rdata[10]));

endmodule

bind dbg_ctrl_reg dbg_ctrl_checker #(
    .REG_W    (REG_W),
    .REV_CODE (REV_CODE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_wr_en      (cpu_wr_en),
    .cpu_rdata      (cpu_rdata),
    .ext_wr_en      (ext_wr_en),
    .ext_wdata      (ext_wdata),
    .ext_rdata      (ext_rdata),
    .sample_pt      (sample_pt),
    .irq_ack        (irq_ack),
    .cpu_super      (cpu_super),
    .ctl_bkpt_mode  (ctl_bkpt_mode),
    .ctl_wr_inhibit (ctl_wr_inhibit),
    .dbg_irq_pend   (dbg_irq_pend),
    .dbg_irq_req    (dbg_irq_req),
    .halt_ok        (halt_ok)
);

// File: tb/dbg_ctrl_reg_bench.sv
module dbg_ctrl_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        ext_wr_en = 1'b0;
    logic [31:0] ext_wdata = '0;
    logic [31:0] ext_rdata;
    logic        bkpt_n = 1'b1;
    logic        sample_pt = 1'b0;
    logic        irq_ack = 1'b0;
    logic        cpu_super = 1'b0;
    logic        ctl_bkpt_mode, ctl_trace_off, ctl_wr_inhibit, ctl_map;
    logic        ctl_trc_emu, ctl_force_emu, ctl_user_halt;
    logic [1:0]  ctl_capture;
    logic        dbg_irq_pend, dbg_irq_req, halt_ok;

    int unsigned n_total = 0;
    int unsigned n_bad   = 0;
    bit          finished = 1'b0;
    logic [8:0]  model = '0;

    always #4 clk = ~clk;

    dbg_ctrl_reg u_dbg_ctrl_reg (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_wr_en(ext_wr_en), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .bkpt_n(bkpt_n), .sample_pt(sample_pt), .irq_ack(irq_ack),
        .cpu_super(cpu_super),
        .ctl_bkpt_mode(ctl_bkpt_mode), .ctl_trace_off(ctl_trace_off),
        .ctl_wr_inhibit(ctl_wr_inhibit), .ctl_map(ctl_map),
        .ctl_trc_emu(ctl_trc_emu), .ctl_force_emu(ctl_force_emu),
        .ctl_capture(ctl_capture), .ctl_user_halt(ctl_user_halt),
        .dbg_irq_pend(dbg_irq_pend), .dbg_irq_req(dbg_irq_req),
        .halt_ok(halt_ok)
    );

    function automatic logic [8:0] next_model(logic [8:0] cur, logic cw, logic [31:0] cd,
                                              logic ew, logic [31:0] ed);
        if (ew) return ed[18:10];
        if (cw && !cur[6]) return {cd[18:17], cur[6], cd[15:10]};
        return cur;
    endfunction

    function automatic logic [31:0] exp_ext(logic [8:0] f);
        return {8'h00, 4'b1011, 1'b0, f, 10'h000};
    endfunction

    function automatic logic [31:0] exp_cpu(logic [8:0] f);
        return {8'h00, 4'b0000, 1'b0, f, 10'h000};
    endfunction

    function automatic logic [8:0] ctl_vec();
        return {ctl_bkpt_mode, ctl_trace_off, ctl_wr_inhibit, ctl_map,
                ctl_trc_emu, ctl_force_emu, ctl_capture, ctl_user_halt};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(ext_rdata == exp_ext(model), req, ext_rdata, exp_ext(model));
        chk(cpu_rdata == exp_cpu(model), req, cpu_rdata, exp_cpu(model));
        chk(ctl_vec() == model, req, {23'h0, ctl_vec()}, {23'h0, model});
        chk(halt_ok == (cpu_super | model[0]), "R13", {31'h0, halt_ok},
            {31'h0, cpu_super | model[0]});
    endtask

    // drive one cycle of writes, sample after the edge
    task automatic write_cycle(input logic cw, input logic [31:0] cd,
                               input logic ew, input logic [31:0] ed);
        cpu_wr_en = cw; cpu_wdata = cd; ext_wr_en = ew; ext_wdata = ed;
        @(negedge clk);
        model = next_model(model, cw, cd, ew, ed);
        cpu_wr_en = 1'b0; ext_wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic pend, input logic req, input string tag);
        chk(dbg_irq_pend == pend && dbg_irq_req == req, tag,
            {30'h0, dbg_irq_pend, dbg_irq_req}, {30'h0, pend, req});
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        tick(3);
        // R1 reset state
        check_regs("R1");
        chk_irq(1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        tick(1);

        // R4 external write of all fields
        write_cycle(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
        check_regs("R4");
        // R2 R3 reads after an all-ones write
        chk(ext_rdata == 32'h00B7_FC00, "R2", ext_rdata, 32'h00B7_FC00);
        chk(cpu_rdata == 32'h0007_FC00, "R3", cpu_rdata, 32'h0007_FC00);
        // R6 locked: processor write ignored
        write_cycle(1'b1, 32'h0, 1'b0, '0);
        chk(ext_rdata == 32'h00B7_FC00, "R6", ext_rdata, 32'h00B7_FC00);
        // unlock, then R5 processor write cannot set the lock
        write_cycle(1'b0, '0, 1'b1, 32'h0000_0000);
        write_cycle(1'b1, 32'hFFFF_FFFF, 1'b0, '0);
        chk(ext_rdata == 32'h00B6_FC00, "R5", ext_rdata, 32'h00B6_FC00);
        // R7 simultaneous writes
        write_cycle(1'b1, 32'h0006_0000, 1'b1, 32'h0000_0C00);
        chk(ext_rdata == 32'h00B0_0C00, "R7", ext_rdata, 32'h00B0_0C00);
        check_regs("R7");

        // random mix of writes
        for (int i = 0; i < 400; i++) begin
            cpu_super = 1'($urandom_range(0, 1));
            write_cycle(1'($urandom_range(0, 1)), $urandom,
                        ($urandom_range(0, 3) == 0), $urandom);
            check_regs("R4");
        end

        // breakpoint directed cases, mode on
        write_cycle(1'b0, '0, 1'b1, 32'h0004_0000);
        tick(3);
        chk_irq(1'b0, 1'b0, "R8");
        bkpt_n = 1'b0;
        tick(2);
        chk_irq(1'b0, 1'b0, "R8");
        tick(1);
        chk_irq(1'b1, 1'b0, "R8");
        tick(6);
        chk_irq(1'b1, 1'b0, "R10");
        sample_pt = 1'b1;
        tick(1);
        sample_pt = 1'b0;
        chk_irq(1'b0, 1'b1, "R10");
        // R11 edge while servicing is ignored
        bkpt_n = 1'b1; tick(4);
        bkpt_n = 1'b0; tick(5);
        chk_irq(1'b0, 1'b1, "R11");
        // R12 acknowledge clears
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        chk_irq(1'b0, 1'b0, "R12");
        // new edge accepted again after ack
        bkpt_n = 1'b1; tick(4);
        bkpt_n = 1'b0; tick(3);
        chk_irq(1'b1, 1'b0, "R12");
        // R11 edge while pending is ignored (no queued second request)
        bkpt_n = 1'b1; tick(4);
        bkpt_n = 1'b0; tick(4);
        chk_irq(1'b1, 1'b0, "R11");
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        chk_irq(1'b0, 1'b0, "R12");
        sample_pt = 1'b1; tick(2); sample_pt = 1'b0;
        chk_irq(1'b0, 1'b0, "R11");
        // R9 rising edge does nothing
        bkpt_n = 1'b1; tick(5);
        chk_irq(1'b0, 1'b0, "R9");
        // R9 mode off: falling edge ignored
        write_cycle(1'b0, '0, 1'b1, 32'h0000_0000);
        bkpt_n = 1'b0; tick(5);
        chk_irq(1'b0, 1'b0, "R9");
        // R13 directed
        cpu_super = 1'b0; tick(1);
        chk(halt_ok == 1'b0, "R13", {31'h0, halt_ok}, 32'h0);
        write_cycle(1'b0, '0, 1'b1, 32'h0000_0400);
        chk(halt_ok == 1'b1, "R13", {31'h0, halt_ok}, 32'h1);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule